// File: doc/BRIEF.md
# One-Time Challenge-Response Access Gate

This block decides whether a requester may read a protected sensor word. Each access session begins with a request. The block answers with a challenge taken from a local table of enrolled challenge/response entries. An entry is handed out at most once. The requester must return the matching response. If it matches exactly, the block reports an authenticated state and waits for a separate confirm command before it releases one sensor word. A wrong response, a silent requester or an empty table ends the session with a denied state and a one-cycle alert.

The table is filled while an enrollment input is held high. Entering enrollment makes every loaded entry available again and abandons any session in progress. Which unused entry is handed out is steered by a free-running linear feedback shift register. A rotating search from the register's position finds the next entry that is loaded and unused.

Top module: `crp_gate`

## Requirements
- R1: After reset, status is 2'b00 (idle/pending), `chal_valid`, `data_valid` and `alert` are low, and `exhausted` is low.
- R2: Table writes (`enr_we`) take effect only while `enroll_en` is high. While `enroll_en` is high, requests are ignored. Any open session is cancelled, status returns to 2'b00, the exhausted flag clears and every loaded entry becomes unused again.
- R3: A request in the idle state, with at least one loaded unused entry, gives a one-cycle `chal_valid` pulse in the next cycle. `chal_out` then holds the challenge of such an entry. Status becomes 2'b00. The selection register seeding the search is never zero.
- R4: Between two enrollments no challenge is issued twice.
- R5: A returned response (`rsp_valid`) equal in every bit to the stored response of the issued entry sets status to 2'b01 (authenticated) in the next cycle. No data is released yet.
- R6: A returned response that differs in any bit sets status to 2'b10 (denied) and pulses `alert` for one cycle. It closes the session, so no data follows.
- R7: After authentication, `confirm` causes a one-cycle `data_valid` in the next cycle. `data_out` carries `sensor_word` as sampled with `confirm`. Status stays 2'b01 and the block returns to idle.
- R8: A response outside the wait-for-response state and a confirm outside the wait-for-confirm state have no effect on status, `alert` or `data_valid`.
- R9: A request when no loaded unused entry remains issues no challenge. It sets status 2'b10, pulses `alert` and raises `exhausted`, which stays high until the next enrollment.
- R10: If `tmo_limit` = L, a session waiting for a response or a confirm is denied (status 2'b10, `alert` pulse) L+1 cycles after entering that wait. The status is still unchanged after L cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enroll_en | input | 1 | Enrollment mode enable |
| enr_we | input | 1 | Table write strobe (enrollment only) |
| enr_idx | input | IDX_W | Table entry written |
| enr_chal | input | CHAL_W | Challenge value written |
| enr_resp | input | RESP_W | Expected response written |
| req | input | 1 | Access request |
| chal_valid | output | 1 | One-cycle challenge issue pulse |
| chal_out | output | CHAL_W | Issued challenge |
| rsp_valid | input | 1 | Requester response strobe |
| rsp_data | input | RESP_W | Requester response |
| confirm | input | 1 | Confirm command after authentication |
| sensor_word | input | DATA_W | Latest sensor data |
| tmo_limit | input | TMO_W | Wait limit in cycles |
| data_valid | output | 1 | One-cycle data release pulse |
| data_out | output | DATA_W | Released sensor word |
| status | output | 2 | 00 idle/pending, 01 authenticated, 10 denied |
| alert | output | 1 | One-cycle refusal pulse |
| exhausted | output | 1 | No unused entries remained at last request |

## Verification
The main function is tried with a correct response followed by confirm, which must release the word. A response with one flipped bit must deny, and a later confirm must do nothing. A confirm sent before the response must be ignored, and a stale response replayed while idle must leave status alone. Silence in either wait state is counted against the exact timeout cycle, so a limit that is off by one cycle is caught. Draining all enrolled entries and then re-enrolling shows that challenges are single-use and that exhaustion clears. Starting enrollment during an open session and then sending a correct response shows the cancellation.

// File: rtl/crp_pkg.sv
package crp_pkg;

    typedef enum logic [1:0] {
        SS_IDLE     = 2'd0,
        SS_WAIT_RSP = 2'd1,
        SS_WAIT_CFM = 2'd2
    } sess_state_t;

    typedef enum logic [1:0] {
        AS_PEND = 2'b00,
        AS_AUTH = 2'b01,
        AS_DENY = 2'b10
    } auth_state_t;

    // Galois feedback masks for maximal-length sequences
    function automatic logic [31:0] lfsr_mask(input int width);
        case (width)
            8:       return 32'h0000_00B8;
            16:      return 32'h0000_B400;
            32:      return 32'h8020_0003;
            default: return 32'h0000_B400;
        endcase
    endfunction

endpackage

// File: rtl/crp_lfsr.sv
module crp_lfsr #(
    parameter int          W    = 16,
    parameter logic [31:0] SEED = 32'h0000_ACE1
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] state
);
    import crp_pkg::*;

    localparam logic [W-1:0] MASK     = W'(lfsr_mask(W));
    localparam logic [W-1:0] SEED_W   = W'(SEED);
    localparam logic [W-1:0] SEED_OK  = (SEED_W == '0) ? W'(1) : SEED_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEED_OK;
        end else begin
            state <= (state >> 1) ^ (state[0] ? MASK : '0);
        end
    end

endmodule

// File: rtl/crp_store.sv
module crp_store #(
    parameter int DEPTH = 16,
    parameter int ENT_W = 96,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [ENT_W-1:0] wr_data,
    input  logic             clr_used,
    input  logic             mark_en,
    input  logic [IDX_W-1:0] mark_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [ENT_W-1:0] rd_data,
    output logic [DEPTH-1:0] eligible
);
    logic [ENT_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];

    for (genvar g = 0; g < DEPTH; g++) begin : g_flag
        logic loaded_q;
        logic used_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                loaded_q <= 1'b0;
                used_q   <= 1'b0;
            end else begin
                if (wr_en && wr_idx == IDX_W'(g)) begin
                    loaded_q <= 1'b1;
                end
                if (clr_used) begin
                    used_q <= 1'b0;
                end else if (mark_en && mark_idx == IDX_W'(g)) begin
                    used_q <= 1'b1;
                end
            end
        end

        assign eligible[g] = loaded_q && !used_q;
    end

endmodule

// File: rtl/crp_picker.sv
module crp_picker #(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] eligible,
    input  logic [IDX_W-1:0] start,
    output logic [IDX_W-1:0] pick,
    output logic             found
);
    // rotating first-eligible search beginning at start
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!found && eligible[(int'(start) + i) % DEPTH]) begin
                found = 1'b1;
                pick  = IDX_W'((int'(start) + i) % DEPTH);
            end
        end
    end

endmodule

// File: rtl/crp_gate.sv
module crp_gate #(
    parameter int CHAL_W = 64,
    parameter int RESP_W = 32,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    parameter int LFSR_W = 16,
    parameter int TMO_W  = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int ENT_W = CHAL_W + RESP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enroll_en,
    input  logic              enr_we,
    input  logic [IDX_W-1:0]  enr_idx,
    input  logic [CHAL_W-1:0] enr_chal,
    input  logic [RESP_W-1:0] enr_resp,
    input  logic              req,
    output logic              chal_valid,
    output logic [CHAL_W-1:0] chal_out,
    input  logic              rsp_valid,
    input  logic [RESP_W-1:0] rsp_data,
    input  logic              confirm,
    input  logic [DATA_W-1:0] sensor_word,
    input  logic [TMO_W-1:0]  tmo_limit,
    output logic              data_valid,
    output logic [DATA_W-1:0] data_out,
    output logic [1:0]        status,
    output logic              alert,
    output logic              exhausted
);
    import crp_pkg::*;

    typedef struct packed {
        logic [CHAL_W-1:0] chal;
        logic [RESP_W-1:0] resp;
    } crp_entry_t;

    sess_state_t       state_q;
    auth_state_t       auth_q;
    logic [TMO_W-1:0]  timer_q;
    logic [RESP_W-1:0] exp_resp_q;
    logic [CHAL_W-1:0] chal_q;
    logic              chal_v_q;
    logic [DATA_W-1:0] data_q;
    logic              data_v_q;
    logic              alert_q;
    logic              exh_q;

    logic [LFSR_W-1:0] lfsr_q;
    logic [IDX_W-1:0]  start_idx;
    logic [IDX_W-1:0]  pick_idx;
    logic              pick_found;
    logic [DEPTH-1:0]  eligible;
    logic [ENT_W-1:0]  rd_raw;
    crp_entry_t        rd_entry;
    crp_entry_t        wr_entry;
    logic              issue_go;
    logic              wait_expired;

    crp_lfsr #(.W(LFSR_W)) u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .state (lfsr_q)
    );

    // fold every register bit into the search start position
    always_comb begin
        start_idx = '0;
        for (int i = 0; i < LFSR_W; i++) begin
            start_idx[i % IDX_W] = start_idx[i % IDX_W] ^ lfsr_q[i];
        end
    end

    crp_picker #(.DEPTH(DEPTH)) u_pick (
        .eligible (eligible),
        .start    (start_idx),
        .pick     (pick_idx),
        .found    (pick_found)
    );

    assign wr_entry = '{chal: enr_chal, resp: enr_resp};
    assign rd_entry = crp_entry_t'(rd_raw);
    assign issue_go = !enroll_en && state_q == SS_IDLE && req && pick_found;

    crp_store #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (enroll_en && enr_we),
        .wr_idx   (enr_idx),
        .wr_data  (wr_entry),
        .clr_used (enroll_en),
        .mark_en  (issue_go),
        .mark_idx (pick_idx),
        .rd_idx   (pick_idx),
        .rd_data  (rd_raw),
        .eligible (eligible)
    );

    assign wait_expired = (timer_q == tmo_limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= SS_IDLE;
            auth_q     <= AS_PEND;
            timer_q    <= '0;
            exp_resp_q <= '0;
            chal_q     <= '0;
            chal_v_q   <= 1'b0;
            data_q     <= '0;
            data_v_q   <= 1'b0;
            alert_q    <= 1'b0;
            exh_q      <= 1'b0;
        end else begin
            chal_v_q <= 1'b0;
            data_v_q <= 1'b0;
            alert_q  <= 1'b0;
            if (enroll_en) begin
                state_q <= SS_IDLE;
                auth_q  <= AS_PEND;
                timer_q <= '0;
                exh_q   <= 1'b0;
            end else begin
                unique case (state_q)
                    SS_IDLE: begin
                        if (req) begin
                            if (pick_found) begin
                                chal_q     <= rd_entry.chal;
                                exp_resp_q <= rd_entry.resp;
                                chal_v_q   <= 1'b1;
                                auth_q     <= AS_PEND;
                                timer_q    <= '0;
                                state_q    <= SS_WAIT_RSP;
                            end else begin
                                auth_q  <= AS_DENY;
                                alert_q <= 1'b1;
                                exh_q   <= 1'b1;
                            end
                        end
                    end
                    SS_WAIT_RSP: begin
                        if (rsp_valid) begin
                            timer_q <= '0;
                            if (rsp_data == exp_resp_q) begin
                                auth_q  <= AS_AUTH;
                                state_q <= SS_WAIT_CFM;
                            end else begin
                                auth_q  <= AS_DENY;
                                alert_q <= 1'b1;
                                state_q <= SS_IDLE;
                            end
                        end else if (wait_expired) begin
                            auth_q  <= AS_DENY;
                            alert_q <= 1'b1;
                            state_q <= SS_IDLE;
                        end else begin
                            timer_q <= timer_q + 1'b1;
                        end
                    end
                    SS_WAIT_CFM: begin
                        if (confirm) begin
                            data_q   <= sensor_word;
                            data_v_q <= 1'b1;
                            state_q  <= SS_IDLE;
                        end else if (wait_expired) begin
                            auth_q  <= AS_DENY;
                            alert_q <= 1'b1;
                            state_q <= SS_IDLE;
                        end else begin
                            timer_q <= timer_q + 1'b1;
                        end
                    end
                    default: state_q <= SS_IDLE;
                endcase
            end
        end
    end

    assign chal_valid = chal_v_q;
    assign chal_out   = chal_q;
    assign data_valid = data_v_q;
    assign data_out   = data_q;
    assign status     = auth_q;
    assign alert      = alert_q;
    assign exhausted  = exh_q;

endmodule

// File: rtl/crp_gate_chk.sv
module crp_gate_chk #(
    parameter int LFSR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req,
    input logic              enroll_en,
    input logic              confirm,
    input logic              chal_valid,
    input logic              data_valid,
    input logic              alert,
    input logic [1:0]        status,
    input logic              exhausted,
    input logic [LFSR_W-1:0] lfsr_state
);
    // R3
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        lfsr_state != '0);

    // R3
    chal_after_req_chk: assert property (@(posedge clk) disable iff (rst)
        chal_valid |-> ($past(req) && !$past(enroll_en)));

    // R7
    data_after_confirm_chk: assert property (@(posedge clk) disable iff (rst)
        data_valid |-> ($past(confirm) && status == 2'b01));

    // R6
    alert_means_deny_chk: assert property (@(posedge clk) disable iff (rst)
        alert |-> status == 2'b10);

    // R2
    enroll_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(enroll_en) |-> (!chal_valid && !data_valid && !alert));

    // R9
    exhausted_deny_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(exhausted) |-> (alert && !chal_valid));

    // R6
    pulse_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({chal_valid, data_valid, alert}));

endmodule

bind crp_gate crp_gate_chk #(.LFSR_W(LFSR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req        (req),
    .enroll_en  (enroll_en),
    .confirm    (confirm),
    .chal_valid (chal_valid),
    .data_valid (data_valid),
    .alert      (alert),
    .status     (status),
    .exhausted  (exhausted),
    .lfsr_state (lfsr_q)
);

// File: tb/crp_gate_tb.sv
module crp_gate_tb;
    localparam int CW = 64, RW = 32, DW = 16, DEP = 16, IW = 4, TW = 16;
    localparam int NENR = 6;
    localparam int LIM = 8;

    logic          clk = 1'b0, rst = 1'b1;
    logic          enroll_en = 0, enr_we = 0, req = 0, rsp_valid = 0, confirm = 0;
    logic [IW-1:0] enr_idx = '0;
    logic [CW-1:0] enr_chal = '0;
    logic [RW-1:0] enr_resp = '0, rsp_data = '0;
    logic [DW-1:0] sensor_word = '0;
    logic [TW-1:0] tmo_limit = TW'(LIM);
    logic          chal_valid, data_valid, alert, exhausted;
    logic [CW-1:0] chal_out;
    logic [DW-1:0] data_out;
    logic [1:0]    status;

    always #4 clk = ~clk;

    crp_gate #(.CHAL_W(CW), .RESP_W(RW), .DATA_W(DW), .DEPTH(DEP), .TMO_W(TW)) u_dut (
        .clk(clk), .rst(rst), .enroll_en(enroll_en), .enr_we(enr_we), .enr_idx(enr_idx),
        .enr_chal(enr_chal), .enr_resp(enr_resp), .req(req), .chal_valid(chal_valid),
        .chal_out(chal_out), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .confirm(confirm),
        .sensor_word(sensor_word), .tmo_limit(tmo_limit), .data_valid(data_valid),
        .data_out(data_out), .status(status), .alert(alert), .exhausted(exhausted)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    typedef struct {
        bit          is_data;
        logic [DW-1:0] val;
    } exp_ev_t;

    exp_ev_t       sb[$];
    logic [CW-1:0] seen[$];

    function automatic logic [CW-1:0] mk_chal(int i);
        return {32'hC0DE_0000 + 32'(i), 32'h1234_5670 + 32'(i)};
    endfunction

    function automatic logic [RW-1:0] mk_resp(int i);
        return 32'(32'h9E37_79B9 * 32'(i + 1));
    endfunction

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push_ev(bit is_data, logic [DW-1:0] v);
        exp_ev_t e;
        e.is_data = is_data;
        e.val = v;
        sb.push_back(e);
    endtask

    // monitor: pops expected pulses as they appear
    always @(negedge clk) begin
        if (!rst) begin
            if (alert) begin
                if (sb.size() == 0) chk(0, "R6 unexpected alert", 1, 0);
                else begin
                    exp_ev_t e;
                    e = sb.pop_front();
                    chk(!e.is_data, "R6 alert where data expected", 1, 0);
                end
            end
            if (data_valid) begin
                if (sb.size() == 0) chk(0, "R7 unexpected data", 64'(data_out), 0);
                else begin
                    exp_ev_t e;
                    e = sb.pop_front();
                    chk(e.is_data && e.val == data_out, "R7 released word", 64'(data_out), 64'(e.val));
                end
            end
        end
    end

    task automatic issue(output int idx);
        logic [CW-1:0] ch;
        req = 1;
        @(negedge clk);
        req = 0;
        chk(chal_valid == 1'b1, "R3 challenge pulse", 64'(chal_valid), 1);
        chk(status == 2'b00, "R3 pending status", 64'(status), 0);
        ch = chal_out;
        idx = -1;
        for (int i = 0; i < NENR; i++) if (mk_chal(i) == ch) idx = i;
        chk(idx >= 0, "R3 challenge from enrolled entry", ch, 0);
        for (int k = 0; k < seen.size(); k++)
            chk(seen[k] != ch, "R4 challenge reused", ch, 0);
        seen.push_back(ch);
        if (idx < 0) idx = 0;
    endtask

    task automatic respond(logic [RW-1:0] r);
        rsp_data = r;
        rsp_valid = 1;
        @(negedge clk);
        rsp_valid = 0;
    endtask

    task automatic do_confirm(logic [DW-1:0] w);
        sensor_word = w;
        confirm = 1;
        @(negedge clk);
        confirm = 0;
        sensor_word = ~w;
    endtask

    task automatic good_session(logic [DW-1:0] w);
        int idx;
        issue(idx);
        respond(mk_resp(idx));
        chk(status == 2'b01, "R5 match authenticates", 64'(status), 1);
        chk(data_valid == 1'b0, "R5 no data before confirm", 64'(data_valid), 0);
        push_ev(1, w);
        do_confirm(w);
        chk(status == 2'b01, "R7 status kept", 64'(status), 1);
        respond(mk_resp(idx));
        chk(status == 2'b01, "R8 replayed response ignored", 64'(status), 1);
    endtask

    initial begin
        int idx;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(status == 2'b00, "R1 status", 64'(status), 0);
        chk(!chal_valid && !data_valid && !alert, "R1 pulses low", 64'({chal_valid, data_valid, alert}), 0);
        chk(exhausted == 1'b0, "R1 exhausted", 64'(exhausted), 0);

        // enrollment of NENR entries, with a request that must be ignored
        enroll_en = 1;
        req = 1;
        for (int i = 0; i < NENR; i++) begin
            enr_we = 1; enr_idx = IW'(i); enr_chal = mk_chal(i); enr_resp = mk_resp(i);
            @(negedge clk);
            chk(chal_valid == 1'b0, "R2 request ignored in enrollment", 64'(chal_valid), 0);
        end
        req = 0;
        enroll_en = 0;
        // write outside enrollment must not load entry NENR
        enr_idx = IW'(NENR); enr_chal = mk_chal(NENR); enr_resp = mk_resp(NENR);
        @(negedge clk);
        enr_we = 0;

        good_session(16'hA5A5);

        // wrong response, then a confirm that must do nothing
        issue(idx);
        push_ev(0, '0);
        respond(mk_resp(idx) ^ 32'h0000_0100);
        chk(status == 2'b10, "R6 mismatch denies", 64'(status), 2);
        do_confirm(16'h1111);
        @(negedge clk);
        chk(status == 2'b10 && data_valid == 1'b0, "R8 confirm after deny ignored", 64'(status), 2);

        // early confirm ignored, then proper completion
        issue(idx);
        do_confirm(16'h2222);
        chk(status == 2'b00 && data_valid == 1'b0, "R8 early confirm ignored", 64'(status), 0);
        respond(mk_resp(idx));
        chk(status == 2'b01, "R5 match after early confirm", 64'(status), 1);
        push_ev(1, 16'h3C3C);
        do_confirm(16'h3C3C);

        // timeout waiting for a response
        issue(idx);
        push_ev(0, '0);
        repeat (LIM) @(negedge clk);
        chk(status == 2'b00, "R10 not denied before limit", 64'(status), 0);
        @(negedge clk);
        chk(status == 2'b10, "R10 response wait expired", 64'(status), 2);

        // timeout waiting for a confirm
        issue(idx);
        respond(mk_resp(idx));
        push_ev(0, '0);
        repeat (LIM) @(negedge clk);
        chk(status == 2'b01, "R10 still authenticated at limit", 64'(status), 1);
        @(negedge clk);
        chk(status == 2'b10, "R10 confirm wait expired", 64'(status), 2);

        good_session(16'h0F0F);

        // all six used: exhaustion (entry 6 was never loaded, R2)
        push_ev(0, '0);
        req = 1;
        @(negedge clk);
        req = 0;
        chk(chal_valid == 1'b0, "R9 no challenge when empty", 64'(chal_valid), 0);
        chk(status == 2'b10, "R9 deny when empty", 64'(status), 2);
        chk(exhausted == 1'b1, "R9 exhausted flag", 64'(exhausted), 1);
        @(negedge clk);
        chk(exhausted == 1'b1, "R9 exhausted held", 64'(exhausted), 1);

        // re-enrollment restores entries
        enroll_en = 1;
        @(negedge clk);
        enroll_en = 0;
        @(negedge clk);
        chk(exhausted == 1'b0, "R2 enrollment clears exhausted", 64'(exhausted), 0);
        chk(status == 2'b00, "R2 enrollment resets status", 64'(status), 0);
        seen.delete();
        good_session(16'h7E57);

        // enrollment cancels an open session
        issue(idx);
        enroll_en = 1;
        @(negedge clk);
        enroll_en = 0;
        respond(mk_resp(idx));
        chk(status == 2'b00, "R2 session cancelled by enrollment", 64'(status), 0);
        @(negedge clk);
        chk(sb.size() == 0, "R7 all expected pulses seen", 64'(sb.size()), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule